// File: doc/BRIEF.md
# LIN Bit-Time Measurement Register

This block holds the length of one serial bit, counted in module clock cycles, for a LIN-style slave interface. The value has two owners, chosen by a mode select. In auto mode the hardware times the break and sync pattern at the head of every frame and publishes the per-bit count. In manual (byte transfer) mode software writes the count to set the bit rate that the byte transfer logic uses.

Software reaches the value through a byte-wide register port with separate high and low bytes. A high-byte write is parked in a shadow register. The full value changes only when the low byte is written. Bit 0 is always held at zero. In auto mode, reads are blanked from the moment the identifier byte arrives until frame activity announces the next frame. During that window the stored value is kept and still drives the bit-time output.

In auto mode the block counts module clocks from the first falling edge of the sync field (0x55) to its fifth falling edge. That span is eight bit times. The count is divided by eight and its LSB is cleared. A count that overflows the counter is discarded and flagged with a one-cycle error pulse.

Top module: `lin_bittime_reg`

## Requirements
- R1: After reset, the bit-time output is 0 and reads of both bytes return 0.
- R2: A high-byte read (reg_sel_hi=1) returns value bits 12..8 in data bits 4..0, with data bits 7..5 at 0. A low-byte read (reg_sel_hi=0) returns value bits 7..1 in data bits 7..1, with data bit 0 at 0.
- R3: An odd low-byte write is stored as the next lower even value; writing 0x33 reads back 0x32 and gives a value of 50.
- R4: In manual mode (mode_byte=1), a high-byte write leaves the value unchanged. The next low-byte write commits the shadowed high byte and the low byte together in one cycle.
- R5: In auto mode (mode_byte=0), register writes have no effect on the value.
- R6: In auto mode, a break (rx low for at least BRK_MIN clocks) is followed by a delimiter and a 0x55 sync byte with bits of B clocks each. The value then becomes B with its LSB cleared, which is the first-to-fifth falling-edge count divided by 8 with the LSB cleared.
- R7: In manual mode, a break and sync on rx leave the value unchanged.
- R8: In auto mode, after an id_rcvd pulse both bytes read 0, while the bit-time output keeps its value, until a frame_act pulse restores the reads.
- R9: A sync measurement whose count reaches the counter's all-ones value before the fifth falling edge is discarded. The value stays unchanged and meas_err pulses high for exactly one cycle.
- R10: A low period shorter than BRK_MIN clocks is not taken as a break, and the sync that follows it does not change the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_byte | input | 1 | 1 = manual byte transfer mode, 0 = auto LIN mode |
| rx | input | 1 | Serial receive line, idle high |
| frame_act | input | 1 | Pulse: activity marking the start of a frame |
| id_rcvd | input | 1 | Pulse: identifier byte received |
| reg_wr | input | 1 | Register write strobe |
| reg_sel_hi | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| bt_value | output | BT_W | Bit-time value in effect |
| meas_err | output | 1 | One-cycle pulse on a discarded, overflowed measurement |

## Verification
The hardest condition to reach from the ports is the overflow discard. It needs a sync field whose eight bit times exceed the full counter range, so the bench sends one frame with bits of 8200 clocks. It then switches the mode to manual and back, which returns the measurement engine to idle before the recovery frame. The read lockout comes next in difficulty, because it depends on the order of id_rcvd and frame_act pulses. Directed sequences place those pulses between measured frames. Random register writes, with a bench model of the shadow byte, cover the two-step commit.

// File: rtl/lin_bt_pkg.sv
// Shared types for the bit-time measurement block.
package lin_bt_pkg;
    // Measurement engine states.
    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,   // hunting for a long low period (break)
        MS_BREAK = 2'd1,   // break seen, waiting for the line to rise
        MS_DELIM = 2'd2,   // delimiter, waiting for the sync start edge
        MS_SYNC  = 2'd3    // timing the sync field
    } meas_state_t;
endpackage

// File: rtl/lin_bt_rxsync.sv
// Synchronizes the asynchronous rx line and flags its edges.
// Assumes the line idles high; reset fills the chain with ones.
module lin_bt_rxsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the line through the synchronizer and remember the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rx_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Edge flags from the synchronized sample against the previous one.
    always_comb begin
        rx_s = chain_q[STAGES-1];
        fall = last_q & ~rx_s;
        rise = ~last_q & rx_s;
    end
endmodule

// File: rtl/lin_bt_meas.sv
// Times the break and sync pattern and reports the per-bit count.
// Assumes the sync byte is 0x55: the first to fifth falling edges span
// eight bit times. Runs only while en is high; otherwise it sits idle.
module lin_bt_meas
    import lin_bt_pkg::*;
#(
    parameter int BT_W    = 13,
    parameter int BRK_MIN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            rx_s,
    input  logic            fall,
    input  logic            rise,
    output logic            vld,
    output logic [BT_W-1:0] val,
    output logic            err
);
    localparam int CNT_W = BT_W + 3;
    localparam int BRK_W = $clog2(BRK_MIN + 1);
    localparam logic [BRK_W-1:0] BRK_LAST = BRK_W'(BRK_MIN - 1);
    localparam logic [2:0] LAST_FALL = 3'd4;

    meas_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BRK_W-1:0] brk_q;
    logic [2:0]       nfall_q;

    // Sequence the break hunt, delimiter wait and sync timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= MS_IDLE;
            cnt_q   <= '0;
            brk_q   <= '0;
            nfall_q <= '0;
            vld     <= 1'b0;
            err     <= 1'b0;
            val     <= '0;
        end else begin
            vld <= 1'b0;
            err <= 1'b0;
            if (!en) begin
                st_q  <= MS_IDLE;
                brk_q <= '0;
            end else begin
                case (st_q)
                    MS_IDLE: begin
                        if (rx_s) begin
                            brk_q <= '0;
                        end else if (brk_q == BRK_LAST) begin
                            st_q  <= MS_BREAK;
                            brk_q <= '0;
                        end else begin
                            brk_q <= brk_q + 1'b1;
                        end
                    end
                    MS_BREAK: begin
                        if (rise) st_q <= MS_DELIM;
                    end
                    MS_DELIM: begin
                        if (fall) begin
                            st_q    <= MS_SYNC;
                            cnt_q   <= CNT_W'(1);
                            nfall_q <= 3'd1;
                        end
                    end
                    MS_SYNC: begin
                        if (fall && nfall_q == LAST_FALL) begin
                            vld  <= 1'b1;
                            val  <= {cnt_q[CNT_W-1:4], 1'b0};
                            st_q <= MS_IDLE;
                        end else if (&cnt_q) begin
                            err  <= 1'b1;
                            st_q <= MS_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            if (fall) nfall_q <= nfall_q + 1'b1;
                        end
                    end
                    default: st_q <= MS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lin_bt_regs.sv
// Holds the bit-time value, the high-byte shadow and the read lockout.
// Assumes 9 <= BT_W <= 15, so the high byte carries BT_W-8 bits.
module lin_bt_regs #(
    parameter int BT_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_byte,
    input  logic            wr,
    input  logic            sel_hi,
    input  logic [7:0]      wdata,
    input  logic            meas_vld,
    input  logic [BT_W-1:0] meas_val,
    input  logic            frame_act,
    input  logic            id_rcvd,
    output logic [7:0]      rdata,
    output logic [BT_W-1:0] bt
);
    localparam int HI_W = BT_W - 8;

    logic [HI_W-1:0] shadow_q;
    logic            lock_q;
    logic            blank;

    // Park high-byte writes in the shadow while software owns the value.
    always_ff @(posedge clk) begin
        if (!rst_n)                       shadow_q <= '0;
        else if (mode_byte && wr && sel_hi) shadow_q <= wdata[HI_W-1:0];
    end

    // Commit on a low-byte write in manual mode or on a measurement in auto mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bt <= '0;
        else if (mode_byte && wr && !sel_hi)
            bt <= {shadow_q, wdata[7:1], 1'b0};
        else if (!mode_byte && meas_vld)
            bt <= {meas_val[BT_W-1:1], 1'b0};
    end

    // Track the window from identifier reception to the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                       lock_q <= 1'b0;
        else if (mode_byte || frame_act)  lock_q <= 1'b0;
        else if (id_rcvd)                 lock_q <= 1'b1;
    end

    // Present the selected byte, blanked while the lockout window is open.
    always_comb begin
        blank = lock_q && !mode_byte;
        if (blank)       rdata = 8'h00;
        else if (sel_hi) rdata = {{(8-HI_W){1'b0}}, bt[BT_W-1:8]};
        else             rdata = {bt[7:1], 1'b0};
    end
endmodule

// File: rtl/lin_bittime_reg.sv
// Top of the bit-time register: rx synchronizer, measurement engine and
// software-visible register with lockout. Assumes frame_act and id_rcvd
// are single-cycle pulses in the clk domain.
module lin_bittime_reg #(
    parameter int BT_W        = 13,
    parameter int BRK_MIN     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_byte,
    input  logic            rx,
    input  logic            frame_act,
    input  logic            id_rcvd,
    input  logic            reg_wr,
    input  logic            reg_sel_hi,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic [BT_W-1:0] bt_value,
    output logic            meas_err
);
    logic            rx_s, rx_fall, rx_rise;
    logic            m_vld;
    logic [BT_W-1:0] m_val;

    lin_bt_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .rx_s(rx_s), .fall(rx_fall), .rise(rx_rise)
    );

    lin_bt_meas #(.BT_W(BT_W), .BRK_MIN(BRK_MIN)) u_meas (
        .clk(clk), .rst_n(rst_n), .en(!mode_byte),
        .rx_s(rx_s), .fall(rx_fall), .rise(rx_rise),
        .vld(m_vld), .val(m_val), .err(meas_err)
    );

    lin_bt_regs #(.BT_W(BT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte),
        .wr(reg_wr), .sel_hi(reg_sel_hi), .wdata(reg_wdata),
        .meas_vld(m_vld), .meas_val(m_val),
        .frame_act(frame_act), .id_rcvd(id_rcvd),
        .rdata(reg_rdata), .bt(bt_value)
    );
endmodule

// File: rtl/lin_bt_chk.sv
// Property checker for lin_bittime_reg, attached by bind below.
module lin_bt_chk #(
    parameter int BT_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_byte,
    input logic            frame_act,
    input logic            id_rcvd,
    input logic            reg_wr,
    input logic            reg_sel_hi,
    input logic [7:0]      reg_wdata,
    input logic [7:0]      reg_rdata,
    input logic [BT_W-1:0] bt_value,
    input logic            meas_err
);
    localparam int HI_W = BT_W - 8;

    a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_hi |-> reg_rdata[7:HI_W] == '0);

    a_r2_lo_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel_hi |-> !reg_rdata[0]);

    a_r3_value_even: assert property (@(posedge clk) disable iff (!rst_n)
        !bt_value[0]);

    a_r4_hi_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && reg_wr && reg_sel_hi) |=> $stable(bt_value));

    a_r4_lo_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte && reg_wr && !reg_sel_hi) |=> bt_value[7:1] == $past(reg_wdata[7:1]));

    a_r8_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(id_rcvd && !mode_byte && !frame_act) && !mode_byte) |-> reg_rdata == 8'h00);

    a_r9_err_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_err && !mode_byte) |=> $stable(bt_value));
endmodule

bind lin_bittime_reg lin_bt_chk #(.BT_W(BT_W)) u_chk (.*);

// File: tb/tb_lin_bittime_reg.sv
`timescale 1ns/1ps
module tb_lin_bittime_reg;
    localparam int BT_W = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_byte = 1'b0;
    logic            rx = 1'b1;
    logic            frame_act = 1'b0;
    logic            id_rcvd = 1'b0;
    logic            reg_wr = 1'b0;
    logic            reg_sel_hi = 1'b0;
    logic [7:0]      reg_wdata = 8'h00;
    logic [7:0]      reg_rdata;
    logic [BT_W-1:0] bt_value;
    logic            meas_err;

    int total = 0;
    int bad = 0;
    int err_pulses = 0;
    int model_bt = 0;
    int model_sh = 0;

    lin_bittime_reg dut (.*);

    always #2.5 clk = ~clk;

    // Count error pulses away from the active edge.
    always @(negedge clk) if (rst_n && meas_err) err_pulses++;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel_hi = hi; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_byte(input bit hi, output int d);
        @(negedge clk);
        reg_sel_hi = hi;
        #1 d = int'(reg_rdata);
    endtask

    task automatic pulse(input bit is_id);
        @(negedge clk);
        if (is_id) id_rcvd = 1'b1; else frame_act = 1'b1;
        @(negedge clk);
        id_rcvd = 1'b0; frame_act = 1'b0;
    endtask

    // Break of brk clocks, delimiter, then 0x55 framed with start and stop bits.
    task automatic send_frame(input int b, input int brk);
        logic [9:0] bits;
        bits = {1'b1, 8'h55, 1'b0};
        @(negedge clk);
        rx = 1'b0;
        repeat (brk) @(negedge clk);
        rx = 1'b1;
        repeat (b) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            rx = bits[i];
            repeat (b) @(negedge clk);
        end
        rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic toggle_mode();
        @(negedge clk); mode_byte = 1'b1;
        @(negedge clk); mode_byte = 1'b0;
    endtask

    function automatic int exp_meas(input int b);
        return b & ~1;
    endfunction

    // Check both bytes against an expected value.
    task automatic chk_reads(input string tag, input int v);
        int h, l;
        rd_byte(1'b1, h);
        rd_byte(1'b0, l);
        chk({tag, " hi"}, h, (v >> 8) & 8'h1F);
        chk({tag, " lo"}, l, v & 8'hFE);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d, b, e0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bt_value", int'(bt_value), 0);
        chk_reads("R1", 0);

        // R3 odd write forced even
        mode_byte = 1'b1;
        wr_byte(1'b1, 8'h00);
        wr_byte(1'b0, 8'h33);
        rd_byte(1'b0, d);
        chk("R3 read lo", d, 8'h32);
        chk("R3 value", int'(bt_value), 50);

        // R4 high byte alone does not commit
        wr_byte(1'b1, 8'h05);
        chk("R4 hi only", int'(bt_value), 50);
        wr_byte(1'b0, 8'h80);
        chk("R4 commit", int'(bt_value), 16'h0580);

        // R2 field positions with all bits set
        wr_byte(1'b1, 8'hFF);
        wr_byte(1'b0, 8'hFF);
        chk("R2 value", int'(bt_value), 16'h1FFE);
        chk_reads("R2", 16'h1FFE);
        model_sh = 8'h1F; model_bt = 16'h1FFE;

        // R4 random writes against a shadow model
        for (int i = 0; i < 24; i++) begin
            bit hi;
            logic [7:0] w;
            hi = 1'($urandom_range(0, 1));
            w  = 8'($urandom_range(0, 255));
            wr_byte(hi, w);
            if (hi) model_sh = int'(w) & 8'h1F;
            else    model_bt = (model_sh << 8) | (int'(w) & 8'hFE);
            chk("R4 random value", int'(bt_value), model_bt);
        end
        chk_reads("R2 random", model_bt);

        // R5 writes ignored in auto mode
        @(negedge clk); mode_byte = 1'b0;
        wr_byte(1'b1, 8'h0A);
        wr_byte(1'b0, 8'h11);
        chk("R5 value", int'(bt_value), model_bt);
        chk_reads("R5", model_bt);

        // R6 measured frames with random bit lengths
        for (int i = 0; i < 5; i++) begin
            b = $urandom_range(10, 60);
            send_frame(b, 100);
            model_bt = exp_meas(b);
            chk("R6 measured", int'(bt_value), model_bt);
        end
        chk_reads("R6", model_bt);
        send_frame(1001, 100);
        toggle_mode();
        model_bt = exp_meas(1001);
        chk("R6 long bit", int'(bt_value), model_bt);
        chk_reads("R6 long", model_bt);

        // R8 lockout window
        pulse(1'b1);
        chk_reads("R8 blanked", 0);
        chk("R8 value kept", int'(bt_value), model_bt);
        pulse(1'b0);
        chk_reads("R8 restored", model_bt);

        // R10 short low period is not a break
        send_frame(20, 40);
        chk("R10 no update", int'(bt_value), model_bt);

        // R7 manual mode ignores rx frames
        @(negedge clk); mode_byte = 1'b1;
        send_frame(30, 100);
        chk("R7 no update", int'(bt_value), model_bt);
        @(negedge clk); mode_byte = 1'b0;

        // R9 overflowed measurement discarded
        e0 = err_pulses;
        send_frame(8200, 100);
        toggle_mode();
        chk("R9 value kept", int'(bt_value), model_bt);
        chk("R9 err pulses", err_pulses - e0, 1);
        send_frame(44, 100);
        chk("R9 recovery", int'(bt_value), 44);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule